// File: doc/BRIEF.md
# Sleep Mode Power Controller

This block is the state machine of a device power manager. Software asks for a sleep depth: idle, standby, hibernate, backup or off. The controller moves the device into that depth and back out again. For each state it drives the CPU and bus clock enables, five regulator enables, a RAM retention select, an I/O hold control and a one-cycle pulse that returns the other power-manager registers to their defaults.

The shallow depths are idle and standby. Entry to either waits for a grant from the clock ramp block, which steps the main clock down first. On any wake, the controller raises a one-cycle request that starts the ramp back up. Idle wakes on an enabled interrupt that outranks the priority captured on entry. Standby wakes on any enabled interrupt. Hibernate and backup wake on the external pin or on a backup-domain event. Off is left only through reset.

In each state the regulator enables are resolved from the per-regulator enable bits and the run-in-standby bits. A USB enable overrides the USB regulator bit.

Top module: `sleep_pwr_ctrl`

## Requirements
- R1: After a synchronous active-high reset, the controller is active: `cpu_clk_en`=1, `bus_clk_en`=1, `reg_en`=5'b00111, and every other output is 0.
- R2: `reg_en` bit 0 is the RAM regulator, bit 1 the low-power regulator, bit 2 the switching regulator, bit 3 the USB regulator and bit 4 the PLL regulator. In the active, ramp, idle and wake states, bits 2:0 are 1, bit 3 is `opt_reg_en[0]` OR `usb_enable`, and bit 4 is `opt_reg_en[1]`. A change at the inputs shows one cycle later.
- R3: In the active state, `req_valid` with `req_depth` 1 (idle) or 2 (standby) sets `ramp_dn_req` in the next cycle, and the CPU clock keeps running. The target state is entered in the cycle after `ramp_grant` is seen high.
- R4: In idle, `cpu_clk_en`=0, `bus_clk_en`=1, and the regulators are resolved as in R2.
- R5: Idle wakes only on an irq that is pending and enabled and whose 3-bit priority (irq i in `irq_prio[3i+2:3i]`) is numerically greater than the `cur_prio` sampled with the request. A larger value means a higher priority.
- R6: In standby, both clocks are 0 and bits 2:0 of `reg_en` are 1. USB is on when `opt_reg_en[0]` AND `opt_stby[0]` are both 1, or when `usb_enable` is 1. PLL is on when `opt_reg_en[1]` AND `opt_stby[1]` are both 1. Any pending, enabled irq wakes the controller, whatever its priority.
- R7: `usb_enable`=1 forces `reg_en[3]` on in every state whose switching regulator is on.
- R8: `ram_ret_sel` takes the value of `ram_ret_cfg` on entry to standby or hibernate and holds it while there. It reads 0 in every other state.
- R9: `req_depth` 3 enters hibernate in the next cycle, with no grant needed. Both clocks are 0 and `reg_en`=5'b00011. Interrupts are ignored there. `wake_pin` or `bu_wake` wakes it.
- R10: `req_depth` 4 enters backup in the next cycle, with `reg_en`=5'b00010 and both clocks 0. It wakes as in R9.
- R11: `regs_rst` is high for exactly the first cycle of hibernate or backup. The I/O retention bit survives this reset.
- R12: `ioret_set` and `ioret_clr` pulses set and clear the I/O retention bit. `io_hold` rises on entry to hibernate or backup when that bit is set. It stays high through the wake until `ioret_clr`.
- R13: `req_depth` 5 enters off, where `reg_en`=0 and both clocks are 0. Only reset leaves off.
- R14: A wake spends one cycle with `ramp_up_start`=1, `cpu_clk_en`=0, `bus_clk_en`=1 and the regulators resolved as in R2, then returns to active. A request with depth 0, 6 or 7 is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Sleep request strobe |
| req_depth | input | 3 | Requested depth code |
| cur_prio | input | PRIO_W | Current interrupt priority level |
| ramp_grant | input | 1 | Clock ramp block reports the clock is stepped down |
| irq_pend | input | NUM_IRQ | Pending interrupt lines |
| irq_en | input | NUM_IRQ | Interrupt enables |
| irq_prio | input | NUM_IRQ*PRIO_W | Packed per-line priorities |
| wake_pin | input | 1 | External wake pin |
| bu_wake | input | 1 | Backup-domain wake event |
| opt_reg_en | input | 2 | USB (bit 0) and PLL (bit 1) regulator enable bits |
| opt_stby | input | 2 | Run-in-standby bits, same order |
| usb_enable | input | 1 | USB controller enabled |
| ram_ret_cfg | input | 1 | Retention choice: 0 full, 1 partial |
| ioret_set | input | 1 | Set the I/O retention bit |
| ioret_clr | input | 1 | Clear the I/O retention bit and release the hold |
| cpu_clk_en | output | 1 | CPU clock enable |
| bus_clk_en | output | 1 | Bus clock enable |
| reg_en | output | 5 | Regulator enables |
| ram_ret_sel | output | 1 | Latched RAM retention select |
| io_hold | output | 1 | Pad hold |
| regs_rst | output | 1 | Register default pulse |
| ramp_dn_req | output | 1 | Asks the clock ramp block to step down |
| ramp_up_start | output | 1 | Starts the clock ramp up |

## Verification
The hardest case to reach from the ports is the idle priority filter. The filter compares each irq with a priority captured when the request is accepted, not with the live `cur_prio`. The stimulus therefore enters idle with `cur_prio`=3 and then raises an enabled irq of equal priority and a disabled irq of higher priority, and neither may wake the controller. Only after that does it enable the higher irq. Persistent state is probed across deep sleep: the retention select is changed while the controller sleeps, and `io_hold` is observed after the wake from hibernate.

// File: rtl/spc_pkg.sv
package spc_pkg;

  typedef enum logic [2:0] {
    ST_ACTIVE = 3'd0,
    ST_RAMP   = 3'd1,
    ST_IDLE   = 3'd2,
    ST_STBY   = 3'd3,
    ST_HIB    = 3'd4,
    ST_BKP    = 3'd5,
    ST_OFF    = 3'd6,
    ST_WAKE   = 3'd7
  } spc_state_e;

  localparam logic [2:0] DEPTH_IDLE = 3'd1;
  localparam logic [2:0] DEPTH_STBY = 3'd2;
  localparam logic [2:0] DEPTH_HIB  = 3'd3;
  localparam logic [2:0] DEPTH_BKP  = 3'd4;
  localparam logic [2:0] DEPTH_OFF  = 3'd5;

  localparam int REG_N   = 5;
  localparam int REG_RAM = 0;
  localparam int REG_LP  = 1;
  localparam int REG_SW  = 2;
  localparam int OPT_N   = 2;
  localparam int OPT_BASE = 3;
  localparam int OPT_USB = 0;

  function automatic logic is_deep(input spc_state_e s);
    return (s == ST_HIB) || (s == ST_BKP);
  endfunction

  function automatic logic is_awake(input spc_state_e s);
    return (s == ST_ACTIVE) || (s == ST_RAMP) || (s == ST_IDLE) || (s == ST_WAKE);
  endfunction

endpackage

// File: rtl/spc_wake_eval.sv
module spc_wake_eval #(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3
) (
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic [PRIO_W-1:0]         cap_prio,
  output logic                      any_wake,
  output logic                      prio_wake
);
  logic [NUM_IRQ-1:0] live;
  logic [NUM_IRQ-1:0] outranks;

  for (genvar i = 0; i < NUM_IRQ; i++) begin : g_line
    assign live[i]     = irq_pend[i] & irq_en[i];
    assign outranks[i] = live[i] & (irq_prio[i*PRIO_W +: PRIO_W] > cap_prio);
  end

  assign any_wake  = |live;
  assign prio_wake = |outranks;
endmodule

// File: rtl/spc_reg_resolve.sv
module spc_reg_resolve
  import spc_pkg::*;
(
  input  spc_state_e              state,
  input  logic [OPT_N-1:0]        opt_reg_en,
  input  logic [OPT_N-1:0]        opt_stby,
  input  logic                    usb_enable,
  output logic [REG_N-1:0]        reg_en
);
  logic [2:0]       core_on;
  logic [OPT_N-1:0] opt_on;

  always_comb begin
    case (state)
      ST_ACTIVE, ST_RAMP, ST_IDLE, ST_WAKE, ST_STBY: core_on = 3'b111;
      ST_HIB:  core_on = 3'b011;
      ST_BKP:  core_on = 3'b010;
      default: core_on = 3'b000;
    endcase
  end

  for (genvar k = 0; k < OPT_N; k++) begin : g_opt
    logic base_on;
    logic force_on;
    always_comb begin
      if (is_awake(state))      base_on = opt_reg_en[k];
      else if (state == ST_STBY) base_on = opt_reg_en[k] & opt_stby[k];
      else                       base_on = 1'b0;
    end
    if (k == OPT_USB) begin : g_ovr
      assign force_on = usb_enable & (is_awake(state) || state == ST_STBY);
    end else begin : g_plain
      assign force_on = 1'b0;
    end
    assign opt_on[k] = base_on | force_on;
  end

  assign reg_en = {opt_on, core_on};
endmodule

// File: rtl/spc_seq.sv
module spc_seq
  import spc_pkg::*;
#(
  parameter int PRIO_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic [2:0]        req_depth,
  input  logic [PRIO_W-1:0] cur_prio,
  input  logic              ramp_grant,
  input  logic              any_wake,
  input  logic              prio_wake,
  input  logic              wake_pin,
  input  logic              bu_wake,
  input  logic              ram_ret_cfg,
  input  logic              ioret_set,
  input  logic              ioret_clr,
  output spc_state_e        state_q,
  output spc_state_e        state_d,
  output logic [PRIO_W-1:0] cap_q,
  output logic              ram_sel_d,
  output logic              hold_d
);
  spc_state_e        tgt_q, tgt_d;
  logic [PRIO_W-1:0] cap_d;
  logic              ram_sel_q;
  logic              ioret_q, ioret_d;
  logic              hold_q;
  logic              enter_deep;
  logic              enter_keep;

  always_comb begin
    state_d = state_q;
    tgt_d   = tgt_q;
    cap_d   = cap_q;
    case (state_q)
      ST_ACTIVE: begin
        if (req_valid) begin
          case (req_depth)
            DEPTH_IDLE: begin state_d = ST_RAMP; tgt_d = ST_IDLE; cap_d = cur_prio; end
            DEPTH_STBY: begin state_d = ST_RAMP; tgt_d = ST_STBY; cap_d = cur_prio; end
            DEPTH_HIB:  state_d = ST_HIB;
            DEPTH_BKP:  state_d = ST_BKP;
            DEPTH_OFF:  state_d = ST_OFF;
            default:    state_d = ST_ACTIVE;
          endcase
        end
      end
      ST_RAMP: if (ramp_grant) state_d = tgt_q;
      ST_IDLE: if (prio_wake) state_d = ST_WAKE;
      ST_STBY: if (any_wake) state_d = ST_WAKE;
      ST_HIB, ST_BKP: if (wake_pin || bu_wake) state_d = ST_WAKE;
      ST_OFF:  state_d = ST_OFF;
      ST_WAKE: state_d = ST_ACTIVE;
      default: state_d = ST_ACTIVE;
    endcase
    enter_deep = is_deep(state_d) && !is_deep(state_q);
    if (enter_deep) begin
      cap_d = '0;
      tgt_d = ST_IDLE;
    end
  end

  assign enter_keep = ((state_d == ST_STBY) && (state_q != ST_STBY)) ||
                      ((state_d == ST_HIB) && (state_q != ST_HIB));

  always_comb begin
    ram_sel_d = enter_keep ? ram_ret_cfg : ram_sel_q;
    if (ioret_clr)       ioret_d = 1'b0;
    else if (ioret_set)  ioret_d = 1'b1;
    else                 ioret_d = ioret_q;
    if (ioret_clr)                  hold_d = 1'b0;
    else if (enter_deep && ioret_q) hold_d = 1'b1;
    else                            hold_d = hold_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q   <= ST_ACTIVE;
      tgt_q     <= ST_IDLE;
      cap_q     <= '0;
      ram_sel_q <= 1'b0;
      ioret_q   <= 1'b0;
      hold_q    <= 1'b0;
    end else begin
      state_q   <= state_d;
      tgt_q     <= tgt_d;
      cap_q     <= cap_d;
      ram_sel_q <= ram_sel_d;
      ioret_q   <= ioret_d;
      hold_q    <= hold_d;
    end
  end
endmodule

// File: rtl/sleep_pwr_ctrl.sv
module sleep_pwr_ctrl
  import spc_pkg::*;
#(
  parameter int NUM_IRQ = 8,
  parameter int PRIO_W  = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      req_valid,
  input  logic [2:0]                req_depth,
  input  logic [PRIO_W-1:0]         cur_prio,
  input  logic                      ramp_grant,
  input  logic [NUM_IRQ-1:0]        irq_pend,
  input  logic [NUM_IRQ-1:0]        irq_en,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio,
  input  logic                      wake_pin,
  input  logic                      bu_wake,
  input  logic [1:0]                opt_reg_en,
  input  logic [1:0]                opt_stby,
  input  logic                      usb_enable,
  input  logic                      ram_ret_cfg,
  input  logic                      ioret_set,
  input  logic                      ioret_clr,
  output logic                      cpu_clk_en,
  output logic                      bus_clk_en,
  output logic [4:0]                reg_en,
  output logic                      ram_ret_sel,
  output logic                      io_hold,
  output logic                      regs_rst,
  output logic                      ramp_dn_req,
  output logic                      ramp_up_start
);
  spc_state_e        state_q, state_d;
  logic [PRIO_W-1:0] cap_q;
  logic              any_wake, prio_wake;
  logic              ram_sel_d, hold_d;
  logic [REG_N-1:0]  reg_d;

  spc_wake_eval #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) u_wake (
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .irq_prio (irq_prio),
    .cap_prio (cap_q),
    .any_wake (any_wake),
    .prio_wake(prio_wake)
  );

  spc_seq #(.PRIO_W(PRIO_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .req_valid  (req_valid),
    .req_depth  (req_depth),
    .cur_prio   (cur_prio),
    .ramp_grant (ramp_grant),
    .any_wake   (any_wake),
    .prio_wake  (prio_wake),
    .wake_pin   (wake_pin),
    .bu_wake    (bu_wake),
    .ram_ret_cfg(ram_ret_cfg),
    .ioret_set  (ioret_set),
    .ioret_clr  (ioret_clr),
    .state_q    (state_q),
    .state_d    (state_d),
    .cap_q      (cap_q),
    .ram_sel_d  (ram_sel_d),
    .hold_d     (hold_d)
  );

  spc_reg_resolve u_reg (
    .state     (state_d),
    .opt_reg_en(opt_reg_en),
    .opt_stby  (opt_stby),
    .usb_enable(usb_enable),
    .reg_en    (reg_d)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      cpu_clk_en    <= 1'b1;
      bus_clk_en    <= 1'b1;
      reg_en        <= 5'b00111;
      ram_ret_sel   <= 1'b0;
      io_hold       <= 1'b0;
      regs_rst      <= 1'b0;
      ramp_dn_req   <= 1'b0;
      ramp_up_start <= 1'b0;
    end else begin
      cpu_clk_en    <= (state_d == ST_ACTIVE) || (state_d == ST_RAMP);
      bus_clk_en    <= is_awake(state_d);
      reg_en        <= reg_d;
      ram_ret_sel   <= ((state_d == ST_STBY) || (state_d == ST_HIB)) ? ram_sel_d : 1'b0;
      io_hold       <= hold_d;
      regs_rst      <= is_deep(state_d) && !is_deep(state_q);
      ramp_dn_req   <= (state_d == ST_RAMP);
      ramp_up_start <= (state_d == ST_WAKE);
    end
  end
endmodule

// File: rtl/spc_checker.sv
module spc_checker (
  input logic       clk,
  input logic       rst,
  input logic       usb_enable,
  input logic       cpu_clk_en,
  input logic       bus_clk_en,
  input logic [4:0] reg_en,
  input logic       ram_ret_sel,
  input logic       regs_rst,
  input logic       ramp_dn_req,
  input logic       ramp_up_start
);
  assert_cpu_core_supply_R2: assert property (@(posedge clk) disable iff (rst)
    cpu_clk_en |-> (bus_clk_en && reg_en[2:0] == 3'b111));

  assert_ramp_before_sleep_R3: assert property (@(posedge clk) disable iff (rst)
    ($fell(cpu_clk_en) && reg_en[2]) |-> $past(ramp_dn_req));

  assert_usb_override_R7: assert property (@(posedge clk) disable iff (rst)
    ($past(!rst) && $past(usb_enable) && reg_en[2]) |-> reg_en[3]);

  assert_hib_clocks_off_R9: assert property (@(posedge clk) disable iff (rst)
    (reg_en == 5'b00011) |-> (!cpu_clk_en && !bus_clk_en));

  assert_backup_no_ram_R10: assert property (@(posedge clk) disable iff (rst)
    (!reg_en[0] && reg_en[1]) |-> (reg_en[4:2] == 3'b000 && !ram_ret_sel));

  assert_regs_rst_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    regs_rst |=> !regs_rst);

  assert_off_sticky_R13: assert property (@(posedge clk) disable iff (rst)
    (reg_en == 5'b00000) |=> (reg_en == 5'b00000));

  assert_wake_to_active_R14: assert property (@(posedge clk) disable iff (rst)
    ramp_up_start |=> cpu_clk_en);
endmodule

bind sleep_pwr_ctrl spc_checker u_chk (
  .clk          (clk),
  .rst          (rst),
  .usb_enable   (usb_enable),
  .cpu_clk_en   (cpu_clk_en),
  .bus_clk_en   (bus_clk_en),
  .reg_en       (reg_en),
  .ram_ret_sel  (ram_ret_sel),
  .regs_rst     (regs_rst),
  .ramp_dn_req  (ramp_dn_req),
  .ramp_up_start(ramp_up_start)
);

// File: tb/sleep_pwr_ctrl_test.sv
module sleep_pwr_ctrl_test;
  localparam int NUM_IRQ = 8;
  localparam int PRIO_W  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_valid = 1'b0;
  logic [2:0] req_depth = '0;
  logic [PRIO_W-1:0] cur_prio = '0;
  logic ramp_grant = 1'b0;
  logic [NUM_IRQ-1:0] irq_pend = '0;
  logic [NUM_IRQ-1:0] irq_en = '0;
  logic [NUM_IRQ*PRIO_W-1:0] irq_prio = '0;
  logic wake_pin = 1'b0, bu_wake = 1'b0;
  logic [1:0] opt_reg_en = '0, opt_stby = '0;
  logic usb_enable = 1'b0, ram_ret_cfg = 1'b0, ioret_set = 1'b0, ioret_clr = 1'b0;
  logic cpu_clk_en, bus_clk_en, ram_ret_sel, io_hold, regs_rst, ramp_dn_req, ramp_up_start;
  logic [4:0] reg_en;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  logic [11:0] exp_q[$];
  string tag_q[$];

  always #4 clk = ~clk;

  sleep_pwr_ctrl #(.NUM_IRQ(NUM_IRQ), .PRIO_W(PRIO_W)) uut (.*);

  function automatic logic [11:0] ex(input logic cpu, input logic bus, input logic [4:0] rg,
                                     input logic rs, input logic ih, input logic rr,
                                     input logic dn, input logic up);
    return {cpu, bus, rg, rs, ih, rr, dn, up};
  endfunction

  task automatic step(input logic [11:0] e, input string tag);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(negedge clk);
  endtask

  task automatic set_prio(input int line, input logic [PRIO_W-1:0] p);
    irq_prio[line*PRIO_W +: PRIO_W] = p;
  endtask

  initial begin : monitor
    forever begin
      @(posedge clk);
      #2;
      if (exp_q.size() > 0) begin
        logic [11:0] got;
        logic [11:0] want;
        string t;
        want = exp_q.pop_front();
        t = tag_q.pop_front();
        got = {cpu_clk_en, bus_clk_en, reg_en, ram_ret_sel, io_hold, regs_rst, ramp_dn_req, ramp_up_start};
        checks++;
        if (got !== want) begin
          failures++;
          $display("FAIL %s got=%b expected=%b", t, got, want);
        end
      end
    end
  end

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog got=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : driver
    logic [11:0] a0, a1;
    a0 = ex(1, 1, 5'b00111, 0, 0, 0, 0, 0);
    a1 = ex(1, 1, 5'b11111, 0, 0, 0, 0, 0);
    step(a0, "R1 reset");
    step(a0, "R1 reset");
    rst = 1'b0;
    step(a0, "R1 after reset");
    opt_reg_en = 2'b11; opt_stby = 2'b01;
    step(a1, "R2 active regs");

    cur_prio = 3'd3; req_valid = 1'b1; req_depth = 3'd1;
    step(ex(1, 1, 5'b11111, 0, 0, 0, 1, 0), "R3 ramp down");
    req_valid = 1'b0;
    step(ex(1, 1, 5'b11111, 0, 0, 0, 1, 0), "R3 wait grant");
    ramp_grant = 1'b1;
    step(ex(0, 1, 5'b11111, 0, 0, 0, 0, 0), "R4 idle");
    ramp_grant = 1'b0; cur_prio = 3'd0;
    set_prio(2, 3'd3); set_prio(5, 3'd7);
    irq_pend = 8'b0010_0100; irq_en = 8'b0000_0100;
    step(ex(0, 1, 5'b11111, 0, 0, 0, 0, 0), "R5 equal prio no wake");
    step(ex(0, 1, 5'b11111, 0, 0, 0, 0, 0), "R5 disabled high no wake");
    irq_en = 8'b0010_0100;
    step(ex(0, 1, 5'b11111, 0, 0, 0, 0, 1), "R5 higher prio wake");
    irq_pend = '0; irq_en = '0;
    step(a1, "R14 back to active");

    ram_ret_cfg = 1'b1; req_valid = 1'b1; req_depth = 3'd2;
    step(ex(1, 1, 5'b11111, 0, 0, 0, 1, 0), "R3 standby ramp");
    req_valid = 1'b0; ramp_grant = 1'b1;
    step(ex(0, 0, 5'b01111, 1, 0, 0, 0, 0), "R6 standby regs");
    ramp_grant = 1'b0; ram_ret_cfg = 1'b0;
    step(ex(0, 0, 5'b01111, 1, 0, 0, 0, 0), "R8 latched select");
    opt_stby = 2'b00;
    step(ex(0, 0, 5'b00111, 1, 0, 0, 0, 0), "R6 usb off without stby");
    usb_enable = 1'b1;
    step(ex(0, 0, 5'b01111, 1, 0, 0, 0, 0), "R7 usb override");
    set_prio(0, 3'd0); irq_pend = 8'b1; irq_en = 8'b1;
    step(ex(0, 1, 5'b11111, 0, 0, 0, 0, 1), "R6 any irq wake");
    irq_pend = '0; irq_en = '0;
    step(a1, "R14 active");

    ioret_set = 1'b1;
    step(a1, "R12 set bit no hold yet");
    ioret_set = 1'b0; ram_ret_cfg = 1'b1; req_valid = 1'b1; req_depth = 3'd3;
    step(ex(0, 0, 5'b00011, 1, 1, 1, 0, 0), "R9 R11 R12 hibernate entry");
    req_valid = 1'b0;
    step(ex(0, 0, 5'b00011, 1, 1, 0, 0, 0), "R11 pulse ends");
    irq_pend = 8'b0010_0000; irq_en = 8'b0010_0000; ram_ret_cfg = 1'b0;
    step(ex(0, 0, 5'b00011, 1, 1, 0, 0, 0), "R9 irq ignored");
    irq_pend = '0; irq_en = '0; wake_pin = 1'b1;
    step(ex(0, 1, 5'b11111, 0, 1, 0, 0, 1), "R12 hold across wake");
    wake_pin = 1'b0;
    step(ex(1, 1, 5'b11111, 0, 1, 0, 0, 0), "R12 hold in active");
    ioret_clr = 1'b1;
    step(a1, "R12 hold released");
    ioret_clr = 1'b0;

    req_valid = 1'b1; req_depth = 3'd4;
    step(ex(0, 0, 5'b00010, 0, 0, 1, 0, 0), "R10 R11 backup entry");
    req_valid = 1'b0;
    step(ex(0, 0, 5'b00010, 0, 0, 0, 0, 0), "R10 backup");
    bu_wake = 1'b1;
    step(ex(0, 1, 5'b11111, 0, 0, 0, 0, 1), "R10 backup wake");
    bu_wake = 1'b0;
    step(a1, "R14 active");

    req_valid = 1'b1; req_depth = 3'd6;
    step(a1, "R14 depth 6 ignored");
    req_depth = 3'd0;
    step(a1, "R14 depth 0 ignored");

    req_depth = 3'd5;
    step(ex(0, 0, 5'b00000, 0, 0, 0, 0, 0), "R13 off");
    req_valid = 1'b0; wake_pin = 1'b1; irq_pend = 8'hFF; irq_en = 8'hFF;
    step(ex(0, 0, 5'b00000, 0, 0, 0, 0, 0), "R13 no wake from off");
    wake_pin = 1'b0; irq_pend = '0; irq_en = '0; rst = 1'b1;
    step(a0, "R1 reset from off");
    rst = 1'b0;
    step(a1, "R2 R7 active after reset");
    step(a1, "R2 steady");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule